// File: doc/BRIEF.md
# Line-Synchronised Pixel Sequencer

This block paces pixel processing across a video frame. It runs on the system clock and advances only on cycles where a pixel-rate enable is high. With a 48 MHz clock and an enable on every second cycle, this gives a 24 MHz pixel rate. No derived or gated clock is used. After reset it waits until a set number of line-start pulses have gone by, so that the first lines of the incoming video are skipped. It then sweeps a horizontal position counter across one line and parks until the next line-start pulse. That pulse bumps a wrapping vertical line counter and restarts the sweep.

Every output comes from a flop. The state register stays unchanged while a counter runs, so logic decoded from the state does not toggle during a count. The skip, horizontal and vertical counters live beside the state machine, and the state machine reads only their terminal flags. A downstream pixel datapath uses `busy` as its qualifier and the two position outputs as coordinates.

Top module: `px_seq`

## Requirements
- R1: While `rst_n` is low, `h_pos` and `v_pos` read 0, `busy` reads 0, and the machine sits in its start-up skip state.
- R2: In the skip state, each enabled cycle with `line_start` high counts one pulse. `busy` stays 0 through the first `SKIP_LINES` (default 16) pulses and goes to 1 on the enabled cycle after the last of them, with `h_pos` at 0.
- R3: While `busy` is 1, `h_pos` rises by exactly one on each enabled cycle until it equals `H_PIXELS` (default 640). On the next enabled cycle `busy` falls to 0 and `h_pos` holds at `H_PIXELS`.
- R4: After a line ends, `busy` stays 0 and `h_pos` holds until an enabled cycle with `line_start` high. That cycle sets `h_pos` to 0 and `busy` to 1.
- R5: `v_pos` reads 0 for the first processed line. Each line-start pulse that restarts a line raises it by one while it is below `V_LINES` (default 240). At `V_LINES` the pulse wraps it to 0.
- R6: `line_start` while `busy` is 1 has no effect: `v_pos` is unchanged and `h_pos` keeps its one-per-enabled-cycle step.
- R7: On a cycle with `pix_en` low nothing changes, including when `line_start` is high on that cycle.
- R8: The skip count is not cleared when processing starts. After the vertical counter wraps, a single line-start pulse restarts processing, with no new start-up skip.
- R9: Driving `rst_n` low in the middle of a frame returns the block to the R1 state. After release, a full `SKIP_LINES` pulses are again needed before `busy` rises. Reset takes effect at once and is released in step with the clock, two clock edges after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pix_en | input | 1 | Pixel-rate clock enable; the sequencer advances only when high |
| line_start | input | 1 | Line-start pulse, seen only on enabled cycles |
| h_pos | output | $clog2(H_PIXELS+1) | Horizontal position counter |
| v_pos | output | $clog2(V_LINES+1) | Vertical line counter |
| busy | output | 1 | High exactly while a line is being processed |

## Verification
The bench goes after the off-by-one edges of the start-up skip. A design that compared the skip count one step early or late would raise `busy` on the 15th pulse or one pulse after the 16th. It checks the last pixel of a line: an off-by-one in the horizontal bound would leave `busy` high one cycle too short or too long, or let `h_pos` run past 640. It drives line-start pulses in the middle of a line and on disabled cycles; a design that decoded them there would bump `v_pos` or restart the line early. It also runs the vertical counter through its wrap and through a mid-frame reset. A skip count that was cleared on leaving the skip state would stall after the wrap, and a reset that missed a counter would leave stale positions behind.

// File: rtl/px_seq_pkg.sv
package px_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_SKIP = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_GAP  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/px_seq_rst_sync.sv
module px_seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_q_n = chain_q[STAGES-1];

endmodule

// File: rtl/px_seq_cnt.sv
module px_seq_cnt #(
  parameter int MAX  = 16,
  parameter bit WRAP = 1'b0,
  localparam int W   = $clog2(MAX + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] value,
  output logic         at_max
);

  localparam logic [W-1:0] MAX_V = W'(MAX);
  localparam logic [W-1:0] ONE_V = W'(1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic [W-1:0] top_d;

  assign at_max = (cnt_q == MAX_V);

  // value taken when incrementing at the limit: wrap or saturate
  generate
    if (WRAP) begin : g_wrap
      assign top_d = '0;
    end else begin : g_sat
      assign top_d = cnt_q;
    end
  endgenerate

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (inc) begin
      cnt_d = at_max ? top_d : cnt_q + ONE_V;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (en) begin
      cnt_q <= cnt_d;
    end
  end

  assign value = cnt_q;

endmodule

// File: rtl/px_seq_fsm.sv
module px_seq_fsm
  import px_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       line_start,
  input  logic       skip_done,
  input  logic       h_done,
  output seq_state_e state,
  output logic       busy,
  output logic       skip_inc,
  output logic       h_inc,
  output logic       h_clr,
  output logic       v_inc
);

  seq_state_e state_q;
  seq_state_e state_d;
  logic       busy_q;

  // next-state decode: only counter flags and the line pulse steer it
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_SKIP: if (skip_done)  state_d = SEQ_RUN;
      SEQ_RUN:  if (h_done)     state_d = SEQ_GAP;
      SEQ_GAP:  if (line_start) state_d = SEQ_RUN;
      default:                  state_d = SEQ_SKIP;
    endcase
  end

  // counter strobes
  always_comb begin
    skip_inc = (state_q == SEQ_SKIP) && line_start;
    h_inc    = (state_q == SEQ_RUN) && !h_done;
    h_clr    = (state_q == SEQ_GAP) && line_start;
    v_inc    = (state_q == SEQ_GAP) && line_start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_SKIP;
      busy_q  <= 1'b0;
    end else if (en) begin
      state_q <= state_d;
      busy_q  <= (state_d == SEQ_RUN);
    end
  end

  assign state = state_q;
  assign busy  = busy_q;

endmodule

// File: rtl/px_seq.sv
module px_seq
  import px_seq_pkg::*;
#(
  parameter int SKIP_LINES = 16,
  parameter int H_PIXELS   = 640,
  parameter int V_LINES    = 240,
  localparam int HW        = $clog2(H_PIXELS + 1),
  localparam int VW        = $clog2(V_LINES + 1),
  localparam int SW        = $clog2(SKIP_LINES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en,
  input  logic          line_start,
  output logic [HW-1:0] h_pos,
  output logic [VW-1:0] v_pos,
  output logic          busy
);

  logic          rst_q_n;
  seq_state_e    state;
  logic          skip_inc, h_inc, h_clr, v_inc;
  logic          skip_done, h_done, v_top;
  logic [SW-1:0] skip_cnt;

  px_seq_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  px_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .en         (pix_en),
    .line_start (line_start),
    .skip_done  (skip_done),
    .h_done     (h_done),
    .state      (state),
    .busy       (busy),
    .skip_inc   (skip_inc),
    .h_inc      (h_inc),
    .h_clr      (h_clr),
    .v_inc      (v_inc)
  );

  // start-up skip: saturates at its limit, never cleared after reset
  px_seq_cnt #(.MAX(SKIP_LINES), .WRAP(1'b0)) u_skip (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .en     (pix_en),
    .clr    (1'b0),
    .inc    (skip_inc),
    .value  (skip_cnt),
    .at_max (skip_done)
  );

  px_seq_cnt #(.MAX(H_PIXELS), .WRAP(1'b0)) u_hcnt (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .en     (pix_en),
    .clr    (h_clr),
    .inc    (h_inc),
    .value  (h_pos),
    .at_max (h_done)
  );

  px_seq_cnt #(.MAX(V_LINES), .WRAP(1'b1)) u_vcnt (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .en     (pix_en),
    .clr    (1'b0),
    .inc    (v_inc),
    .value  (v_pos),
    .at_max (v_top)
  );

  logic unused_ok;
  assign unused_ok = ^{skip_cnt, v_top};

endmodule

// File: rtl/px_seq_chk.sv
module px_seq_chk
  import px_seq_pkg::*;
#(
  parameter int H_PIXELS = 640,
  parameter int V_LINES  = 240,
  localparam int HW      = $clog2(H_PIXELS + 1),
  localparam int VW      = $clog2(V_LINES + 1)
) (
  input logic          clk,
  input logic          rst_q_n,
  input logic          pix_en,
  input logic          line_start,
  input logic [HW-1:0] h_pos,
  input logic [VW-1:0] v_pos,
  input logic          busy,
  input seq_state_e    state
);

  localparam logic [HW-1:0] H_LAST = HW'(H_PIXELS);
  localparam logic [VW-1:0] V_LAST = VW'(V_LINES);
  localparam logic [HW-1:0] H_ONE  = HW'(1);

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_q_n)
    !pix_en |=> ($stable(h_pos) && $stable(v_pos) && $stable(busy)));

  a_r3_h_step: assert property (@(posedge clk) disable iff (!rst_q_n)
    (busy && pix_en && h_pos < H_LAST) |=> (h_pos == $past(h_pos) + H_ONE));

  a_r3_h_bound: assert property (@(posedge clk) disable iff (!rst_q_n)
    h_pos <= H_LAST);

  a_r3_line_end: assert property (@(posedge clk) disable iff (!rst_q_n)
    (busy && pix_en && h_pos == H_LAST) |=> (!busy && h_pos == H_LAST));

  a_r5_v_bound: assert property (@(posedge clk) disable iff (!rst_q_n)
    v_pos <= V_LAST);

  a_r6_run_ignores_pulse: assert property (@(posedge clk) disable iff (!rst_q_n)
    (busy && pix_en) |=> $stable(v_pos));

  a_r4_gap_hold: assert property (@(posedge clk) disable iff (!rst_q_n)
    (state == SEQ_GAP && pix_en && !line_start) |=> (!busy && $stable(h_pos)));

  a_r4_restart: assert property (@(posedge clk) disable iff (!rst_q_n)
    (state == SEQ_GAP && pix_en && line_start) |=> (busy && h_pos == '0));

  a_r1_skip_quiet: assert property (@(posedge clk) disable iff (!rst_q_n)
    (state == SEQ_SKIP) |-> (!busy && h_pos == '0 && v_pos == '0));

endmodule

bind px_seq px_seq_chk #(.H_PIXELS(H_PIXELS), .V_LINES(V_LINES)) u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .pix_en     (pix_en),
  .line_start (line_start),
  .h_pos      (h_pos),
  .v_pos      (v_pos),
  .busy       (busy),
  .state      (state)
);

// File: tb/test_px_seq.sv
module test_px_seq;

  localparam int CLK_PERIOD = 20;
  localparam int SKIP       = 16;
  localparam int HP         = 640;
  localparam int VL         = 3;
  localparam int HW         = $clog2(HP + 1);
  localparam int VW         = $clog2(VL + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pix_en = 1'b0;
  logic          line_start = 1'b0;
  logic [HW-1:0] h_pos;
  logic [VW-1:0] v_pos;
  logic          busy;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  px_seq #(.SKIP_LINES(SKIP), .H_PIXELS(HP), .V_LINES(VL)) i_px_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_en     (pix_en),
    .line_start (line_start),
    .h_pos      (h_pos),
    .v_pos      (v_pos),
    .busy       (busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one enabled clock edge followed by one disabled edge
  task automatic tick(input bit ls);
    @(negedge clk);
    pix_en = 1'b1;
    line_start = ls;
    @(negedge clk);
    pix_en = 1'b0;
    line_start = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pix_en = 1'b0;
    line_start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 h_pos", int'(h_pos), 0);
    chk("R1 v_pos", int'(v_pos), 0);
    chk("R1 busy", int'(busy), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_skip(input string req);
    for (int i = 0; i < SKIP - 1; i++) begin
      tick(1'b1);
      tick(1'b0);
    end
    chk({req, " busy after 15 pulses"}, int'(busy), 0);
    tick(1'b1);
    chk({req, " busy on last pulse"}, int'(busy), 0);
    tick(1'b0);
    chk({req, " busy after skip"}, int'(busy), 1);
    chk({req, " h_pos at start"}, int'(h_pos), 0);
  endtask

  task automatic t_sweep();
    for (int i = 1; i <= HP; i++) begin
      tick((i % 97) == 5);
      if (i == 100) chk("R3 h_pos mid line", int'(h_pos), 100);
    end
    chk("R3 h_pos at end", int'(h_pos), HP);
    chk("R3 busy at end", int'(busy), 1);
    chk("R6 v_pos after mid-line pulses", int'(v_pos), 0);
    tick(1'b0);
    chk("R3 busy falls", int'(busy), 0);
    chk("R3 h_pos held", int'(h_pos), HP);
  endtask

  task automatic t_gap();
    for (int i = 0; i < 3; i++) tick(1'b0);
    chk("R4 busy in gap", int'(busy), 0);
    chk("R4 h_pos in gap", int'(h_pos), HP);
    @(negedge clk);
    pix_en = 1'b0;
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    chk("R7 busy after disabled pulse", int'(busy), 0);
    chk("R7 v_pos after disabled pulse", int'(v_pos), 0);
    tick(1'b1);
    chk("R4 busy restart", int'(busy), 1);
    chk("R4 h_pos restart", int'(h_pos), 0);
    chk("R5 v_pos first step", int'(v_pos), 1);
  endtask

  task automatic t_wrap();
    int exp_v;
    exp_v = 1;
    for (int ln = 0; ln < VL; ln++) begin
      for (int i = 0; i <= HP; i++) tick(1'b0);
      chk("R3 busy low at line end", int'(busy), 0);
      tick(1'b1);
      exp_v = (exp_v < VL) ? exp_v + 1 : 0;
      chk("R5 v_pos step", int'(v_pos), exp_v);
      chk("R8 busy without new skip", int'(busy), 1);
    end
    chk("R5 v_pos wrapped", int'(v_pos), 0);
  endtask

  task automatic t_reset_mid();
    for (int i = 0; i < 10; i++) tick(1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 h_pos in reset", int'(h_pos), 0);
    chk("R9 busy in reset", int'(busy), 0);
    do_reset();
    t_skip("R9");
  endtask

  initial begin
    t_reset();
    t_skip("R2");
    t_sweep();
    t_gap();
    t_wrap();
    t_reset_mid();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule